// File: doc/BRIEF.md
# Event-Steered Interrupt Status Aggregator

This block turns event messages into interrupt flags. Each message carries an event index, an up/down flag and a count field. The index addresses a small lookup table that software programs. Each table entry holds a valid flag, a target group and a bit position inside that group. An up message sets the target bit and a down message clears it. The count field plays no part.

The block holds a raw status word and an enable word for each of several interrupt groups. The masked status of a group is its raw status ANDed with its enable word. Each group drives one pending line, which is high while any of its masked bits is set. A simple register port gives three operations. The first clears status bits by writing ones, for sources that never send a down message. The other two set and clear enable bits without a read-modify-write. All three honour byte strobes. A read port shows the raw, enable or masked word of any group.

Top module: `evt_irq_steer`

## Requirements
- R1: The event index addresses the lookup table. A table write (`map_wr`) stores {`map_vld`, `map_grp`, `map_bit`} at `map_idx`. A later event uses the entry stored at its index, and its effect shows at the ports on the cycle after the event.
- R2: An event with `ev_up`=1 and a valid entry sets the mapped raw status bit.
- R3: An event with `ev_up`=0 and a valid entry clears the mapped raw status bit.
- R4: `ev_cnt` has no effect: an event gives the same result whatever its count value.
- R5: Raw status bits change whatever the enable state is.
- R6: A register write with `reg_addr`={group, 2'b00} clears every raw bit of that group that is written as 1 in a byte whose `reg_be` bit is set. All other raw bits are kept.
- R7: A write with op 2'b01 sets, and a write with op 2'b10, clears every enable bit written as 1 in a strobed byte. All other enable bits are kept. Op 2'b11 does nothing.
- R8: The masked word (`rd_sel`=2) equals the raw word (`rd_sel`=0) ANDed with the enable word (`rd_sel`=1). `rd_sel`=3 reads as zero.
- R9: `pend[g]` is the OR of the masked bits of group g.
- R10: If an event and a status-clear write hit the same bit in one cycle, the event wins.
- R11: An event whose table entry has its valid flag at 0 changes no status bit.
- R12: After reset, all raw bits, enable bits, table valid flags and pending lines are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Event message present |
| ev_idx | input | IDX_W | Event index |
| ev_up | input | 1 | 1 = up (set), 0 = down (clear) |
| ev_cnt | input | CNT_W | Count field, not used |
| map_wr | input | 1 | Lookup table write strobe |
| map_idx | input | IDX_W | Table entry to write |
| map_vld | input | 1 | Entry valid flag |
| map_grp | input | GRP_W | Target group |
| map_bit | input | BIT_W | Target bit in the group |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | GRP_W+2 | {group, op}: op 0 status clear, 1 enable set, 2 enable clear |
| reg_wdata | input | GW | Write data |
| reg_be | input | GW/8 | Byte strobes |
| rd_grp | input | GRP_W | Group to read |
| rd_sel | input | 2 | 0 raw, 1 enable, 2 masked, 3 zero |
| rd_data | output | GW | Selected word |
| pend | output | NGRP | Pending line per group |

## Verification
A wrong table entry or a wrong update of the status bits leads to a wrong raw word at the read port one cycle after the event that caused it. When an enable bit is set, the fault also shows on `pend` at the same moment. A fault in the enable logic shows at once in the masked word and the pending lines. An inverted priority between events and clears can only be seen when both hit the same bit in the same cycle, so the bench drives that case on purpose.

// File: rtl/evt_irq_steer.sv
module evt_irq_steer #(
  parameter int IDX_W = 4,
  parameter int NGRP  = 4,
  parameter int GW    = 16,
  parameter int CNT_W = 4,
  localparam int GRP_W = $clog2(NGRP),
  localparam int BIT_W = $clog2(GW),
  localparam int NBE   = GW / 8,
  localparam int NENT  = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_valid,
  input  logic [IDX_W-1:0] ev_idx,
  input  logic             ev_up,
  input  logic [CNT_W-1:0] ev_cnt,
  input  logic             map_wr,
  input  logic [IDX_W-1:0] map_idx,
  input  logic             map_vld,
  input  logic [GRP_W-1:0] map_grp,
  input  logic [BIT_W-1:0] map_bit,
  input  logic             reg_wr,
  input  logic [GRP_W+1:0] reg_addr,
  input  logic [GW-1:0]    reg_wdata,
  input  logic [NBE-1:0]   reg_be,
  input  logic [GRP_W-1:0] rd_grp,
  input  logic [1:0]       rd_sel,
  output logic [GW-1:0]    rd_data,
  output logic [NGRP-1:0]  pend
);

  logic [NENT-1:0]                 map_v_q;
  logic [NENT-1:0][GRP_W-1:0]      map_g_q;
  logic [NENT-1:0][BIT_W-1:0]      map_b_q;
  logic [NGRP-1:0][GW-1:0]         raw_q, en_q, raw_d, en_d, msk;
  logic [NGRP-1:0][GW-1:0]         hit_vec, sclr, eset, eclr;
  logic [GW-1:0]                   wbits;

  wire             ev_hit = ev_valid && map_v_q[ev_idx];
  wire [1:0]       op     = reg_addr[1:0];
  wire [GRP_W-1:0] wgrp   = reg_addr[GRP_W+1:2];

  genvar b;
  generate
    for (b = 0; b < NBE; b++) begin : g_be
      assign wbits[b*8 +: 8] = reg_wdata[b*8 +: 8] & {8{reg_be[b]}};
    end
  endgenerate

  always_comb begin
    hit_vec = '0;
    sclr    = '0;
    eset    = '0;
    eclr    = '0;
    if (ev_hit) hit_vec[map_g_q[ev_idx]][map_b_q[ev_idx]] = 1'b1;
    if (reg_wr) begin
      case (op)
        2'b00:   sclr[wgrp] = wbits;
        2'b01:   eset[wgrp] = wbits;
        2'b10:   eclr[wgrp] = wbits;
        default: ;
      endcase
    end
    raw_d = raw_q & ~sclr;
    if (ev_hit) raw_d = ev_up ? (raw_d | hit_vec) : (raw_d & ~hit_vec);
    en_d = (en_q | eset) & ~eclr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raw_q   <= '0;
      en_q    <= '0;
      map_v_q <= '0;
      map_g_q <= '0;
      map_b_q <= '0;
    end else begin
      raw_q <= raw_d;
      en_q  <= en_d;
      if (map_wr) begin
        map_v_q[map_idx] <= map_vld;
        map_g_q[map_idx] <= map_grp;
        map_b_q[map_idx] <= map_bit;
      end
    end
  end

  assign msk = raw_q & en_q;

  genvar g;
  generate
    for (g = 0; g < NGRP; g++) begin : g_pend
      assign pend[g] = |msk[g];
    end
  endgenerate

  always_comb begin
    case (rd_sel)
      2'd0:    rd_data = raw_q[rd_grp];
      2'd1:    rd_data = en_q[rd_grp];
      2'd2:    rd_data = msk[rd_grp];
      default: rd_data = '0;
    endcase
  end

  assert_up_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_hit && ev_up) |=> ((raw_q & $past(hit_vec)) == $past(hit_vec)));

  assert_down_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_hit && !ev_up) |=> ((raw_q & $past(hit_vec)) == '0));

  assert_dropped_event_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && !ev_hit && !reg_wr) |=> $stable(raw_q));

  assert_enable_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr |=> $stable(en_q));

  assert_known_fields_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |-> !$isunknown({ev_idx, ev_up, ev_cnt}));

endmodule

// File: tb/evt_irq_steer_test.sv
module evt_irq_steer_test;
  logic        clk = 0, rst_n = 0;
  logic        ev_valid = 0, ev_up = 0, map_wr = 0, map_vld = 0, reg_wr = 0;
  logic [3:0]  ev_idx = 0, ev_cnt = 0, map_idx = 0, map_bit = 0;
  logic [1:0]  map_grp = 0, rd_grp = 0, rd_sel = 0;
  logic [3:0]  reg_addr = 0;
  logic [15:0] reg_wdata = 0;
  logic [1:0]  reg_be = 0;
  logic [15:0] rd_data;
  logic [3:0]  pend;

  evt_irq_steer uut (.*);

  always #2.5 clk = ~clk;

  typedef struct { logic [1:0] grp; logic [1:0] sel; logic [15:0] exp; logic [3:0] pexp; string tag; } item_t;
  item_t q[$];
  int n_chk = 0, n_fail = 0, busy = 0;

  always begin
    wait (q.size() > 0);
    begin
      item_t it;
      it = q.pop_front();
      rd_grp = it.grp;
      rd_sel = it.sel;
      #1;
      n_chk++;
      if (rd_data !== it.exp) begin
        n_fail++;
        $display("FAIL %s: grp %0d sel %0d data %h expected %h", it.tag, it.grp, it.sel, rd_data, it.exp);
      end
      if (pend !== it.pexp) begin
        n_fail++;
        $display("FAIL %s: pend %b expected %b", it.tag, pend, it.pexp);
      end
      busy--;
    end
  end

  task automatic chk(input logic [1:0] g, input logic [1:0] s, input logic [15:0] e, input logic [3:0] p, input string t);
    item_t it;
    it.grp = g; it.sel = s; it.exp = e; it.pexp = p; it.tag = t;
    busy++;
    q.push_back(it);
    wait (busy == 0);
  endtask

  task automatic map(input int idx, input bit v, input int g, input int bt);
    @(negedge clk);
    map_wr = 1; map_idx = idx[3:0]; map_vld = v; map_grp = g[1:0]; map_bit = bt[3:0];
    @(negedge clk);
    map_wr = 0;
  endtask

  task automatic ev(input int idx, input bit up, input int cnt);
    @(negedge clk);
    ev_valid = 1; ev_idx = idx[3:0]; ev_up = up; ev_cnt = cnt[3:0];
    @(negedge clk);
    ev_valid = 0;
  endtask

  task automatic wr(input int g, input int op, input logic [15:0] d, input logic [1:0] be);
    @(negedge clk);
    reg_wr = 1; reg_addr = {g[1:0], op[1:0]}; reg_wdata = d; reg_be = be;
    @(negedge clk);
    reg_wr = 0;
  endtask

  initial begin
    #200000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    for (int g = 0; g < 4; g++) begin
      chk(g[1:0], 2'd0, 16'h0, 4'b0, "R12 raw");
      chk(g[1:0], 2'd1, 16'h0, 4'b0, "R12 enable");
    end
    ev(3, 1, 0);
    chk(1, 0, 16'h0000, 4'b0, "R12 table invalid after reset");

    map(3, 1, 1, 5);
    map(7, 1, 1, 12);
    map(9, 1, 2, 0);
    map(10, 0, 0, 1);

    ev(3, 1, 0);
    chk(1, 0, 16'h0020, 4'b0, "R1 R2 up sets mapped bit");
    chk(1, 2, 16'h0000, 4'b0, "R5 raw set with enable off");
    ev(7, 1, 15);
    chk(1, 0, 16'h1020, 4'b0, "R4 count ignored");

    wr(1, 1, 16'hFFFF, 2'b01);
    chk(1, 1, 16'h00FF, 4'b0010, "R7 enable set low byte");
    chk(1, 2, 16'h0020, 4'b0010, "R8 R9 masked and pend");
    wr(1, 2, 16'h00F0, 2'b11);
    chk(1, 1, 16'h000F, 4'b0000, "R7 enable clear");
    chk(1, 2, 16'h0000, 4'b0000, "R9 pend drops");
    wr(1, 1, 16'h1000, 2'b10);
    chk(1, 2, 16'h1000, 4'b0010, "R8 masked high bit");
    wr(1, 3, 16'hFFFF, 2'b11);
    chk(1, 1, 16'h100F, 4'b0010, "R7 op3 no effect");
    chk(1, 3, 16'h0000, 4'b0010, "R8 sel3 zero");

    ev(3, 0, 7);
    chk(1, 0, 16'h1000, 4'b0010, "R3 down clears");

    wr(1, 0, 16'hFFFF, 2'b01);
    chk(1, 0, 16'h1000, 4'b0010, "R6 unstrobed byte kept");
    wr(1, 0, 16'hFFFF, 2'b10);
    chk(1, 0, 16'h0000, 4'b0000, "R6 strobed byte cleared");

    ev(10, 1, 0);
    chk(0, 0, 16'h0000, 4'b0000, "R11 invalid entry dropped");

    wr(2, 1, 16'h0001, 2'b01);
    @(negedge clk);
    ev_valid = 1; ev_idx = 4'd9; ev_up = 1; ev_cnt = 0;
    reg_wr = 1; reg_addr = {2'd2, 2'd0}; reg_wdata = 16'h0001; reg_be = 2'b01;
    @(negedge clk);
    ev_valid = 0; reg_wr = 0;
    chk(2, 0, 16'h0001, 4'b0100, "R10 event beats clear");
    wr(2, 0, 16'h0001, 2'b01);
    chk(2, 0, 16'h0000, 4'b0000, "R6 clear alone");

    map(3, 1, 3, 15);
    ev(3, 1, 2);
    chk(3, 0, 16'h8000, 4'b0000, "R1 remapped entry");
    chk(1, 0, 16'h0000, 4'b0000, "R1 old target untouched");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule